// File: doc/BRIEF.md
# Line loss-of-signal qualifier

This block turns two raw level flags from a receive comparator into a clean loss-of-signal alarm. It runs on the recovered line clock, so one clock edge is one unit interval (UI). One flag reports that the received level has dropped below the point at which the alarm should be raised. The other reports that the level has climbed above the point at which the alarm may be withdrawn. The two points are about 1 dB apart, which gives hysteresis. Each direction of change needs its own unbroken run of `PERSIST` UI, 80 by default, before the registered alarm changes state.

While the alarm is up, the recovered serial data passing through the block is forced to 0, so downstream framing never sees noise. When the receiver is in monitor mode or in local loopback, level detection is meaningless. In those modes the alarm is held low, both persistence runs are discarded and data passes through unchanged. The reset input is asynchronous and active low. Its release is synchronised to the line clock inside the block.

Top module: `los_qualifier`

## Requirements
- R1: While reset is applied, and until the first qualifying run completes afterwards, `los_o` is 0 and `rx_data_o` is 0 during reset.
- R2: With `los_o` low and detection enabled, `los_o` rises on the edge that completes `PERSIST` consecutive UI with `below_assert_i` = 1. After `PERSIST`-1 such UI it is still 0. `PERSIST` defaults to 80.
- R3: A single UI with `below_assert_i` = 0 before the run completes restarts the raise count from zero.
- R4: With `los_o` high and detection enabled, `los_o` falls on the edge that completes `PERSIST` consecutive UI with `above_clear_i` = 1. After `PERSIST`-1 such UI it is still 1.
- R5: A single UI with `above_clear_i` = 0 before the run completes restarts the clear count from zero.
- R6: `above_clear_i` has no effect while `los_o` is low, and `below_assert_i` has no effect while `los_o` is high.
- R7: While `los_o` is low after an edge, `rx_data_o` after that edge equals `rx_data_i` sampled at that edge (one UI of latency).
- R8: While `los_o` is high, `rx_data_o` is 0 whatever `rx_data_i` carries.
- R9: Squelching starts on the same edge at which `los_o` rises and ends on the same edge at which it falls.
- R10: A UI with `monitor_en_i` = 1 forces `los_o` low on that edge and discards any partial run, so a following run must again last `PERSIST` UI.
- R11: `loopback_en_i` = 1 has the same effect as `monitor_en_i` in R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered line clock, one edge per UI |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| below_assert_i | input | 1 | Comparator flag: level under the raise threshold |
| above_clear_i | input | 1 | Comparator flag: level over the clear threshold |
| monitor_en_i | input | 1 | Receive monitor mode; suppresses detection |
| loopback_en_i | input | 1 | Local loopback mode; suppresses detection |
| rx_data_i | input | 1 | Recovered serial data |
| rx_data_o | output | 1 | Serial data, forced to 0 while the alarm is set |
| los_o | output | 1 | Registered loss-of-signal alarm |

## Verification
A persistence counter that holds a wrong value shows up only as a shifted alarm edge. A counter that is not cleared by a break or a mode change makes `los_o` move early, sometimes by a single UI. The bench therefore probes the run lengths `PERSIST`-1, `PERSIST` and `PERSIST`+1 exactly, with and without a one-UI break. A wrong alarm state reaches `rx_data_o` within one UI as data that is blanked or leaks through. So every data check compares the output with the bit driven one UI earlier.

// File: rtl/los_pkg.sv
package los_pkg;

  typedef enum logic {
    LOS_CLEAR = 1'b0,
    LOS_SET   = 1'b1
  } los_state_e;

  localparam int unsigned RUN_RAISE = 0;
  localparam int unsigned RUN_CLEAR = 1;
  localparam int unsigned RUN_KINDS = 2;

  function automatic int unsigned run_width(input int unsigned persist);
    return (persist > 1) ? $clog2(persist) : 1;
  endfunction

endpackage

// File: rtl/los_rst_sync.sv
module los_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;

endmodule

// File: rtl/los_persist_ctr.sv
module los_persist_ctr #(
  parameter int unsigned PERSIST = 80
) (
  input  logic clk,
  input  logic rst_n,
  input  logic qualify_i,
  output logic done_o
);

  localparam int unsigned CW = los_pkg::run_width(PERSIST);
  localparam logic [CW-1:0] LAST = CW'(PERSIST - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;
  logic          at_last;

  assign at_last = (cnt_q == LAST);
  assign done_o  = qualify_i && at_last;

  // Any UI without the qualifying condition restarts the run.
  always_comb begin
    cnt_d = '0;
    if (qualify_i && !at_last) begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  assign cnt_en = qualify_i || (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/los_alarm_fsm.sv
module los_alarm_fsm (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 detect_off_i,
  input  logic                 raise_hit_i,
  input  logic                 clear_hit_i,
  output los_pkg::los_state_e  state_o,
  output los_pkg::los_state_e  state_next_o
);

  los_pkg::los_state_e state_q;
  los_pkg::los_state_e state_d;

  always_comb begin
    state_d = state_q;
    if (detect_off_i) begin
      state_d = los_pkg::LOS_CLEAR;
    end else begin
      unique case (state_q)
        los_pkg::LOS_CLEAR: if (raise_hit_i) state_d = los_pkg::LOS_SET;
        los_pkg::LOS_SET:   if (clear_hit_i) state_d = los_pkg::LOS_CLEAR;
        default:            state_d = los_pkg::LOS_CLEAR;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= los_pkg::LOS_CLEAR;
    end else begin
      state_q <= state_d;
    end
  end

  assign state_o      = state_q;
  assign state_next_o = state_d;

endmodule

// File: rtl/los_squelch.sv
module los_squelch (
  input  logic clk,
  input  logic rst_n,
  input  logic squelch_i,
  input  logic data_i,
  output logic data_o
);

  logic data_q;
  logic data_d;

  always_comb begin
    data_d = squelch_i ? 1'b0 : data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= 1'b0;
    end else begin
      data_q <= data_d;
    end
  end

  assign data_o = data_q;

endmodule

// File: rtl/los_qualifier.sv
module los_qualifier #(
  parameter int unsigned PERSIST = 80
) (
  input  logic clk,
  input  logic rst_n,
  input  logic below_assert_i,
  input  logic above_clear_i,
  input  logic monitor_en_i,
  input  logic loopback_en_i,
  input  logic rx_data_i,
  output logic rx_data_o,
  output logic los_o
);

  logic                 rst_core_n;
  logic                 detect_off;
  logic [los_pkg::RUN_KINDS-1:0] run_qual;
  logic [los_pkg::RUN_KINDS-1:0] run_done;
  los_pkg::los_state_e  alarm_q;
  los_pkg::los_state_e  alarm_d;

  los_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  assign detect_off = monitor_en_i || loopback_en_i;

  // Each run only counts in the state it can leave.
  assign run_qual[los_pkg::RUN_RAISE] = !detect_off && (alarm_q == los_pkg::LOS_CLEAR) && below_assert_i;
  assign run_qual[los_pkg::RUN_CLEAR] = !detect_off && (alarm_q == los_pkg::LOS_SET)   && above_clear_i;

  for (genvar g = 0; g < los_pkg::RUN_KINDS; g++) begin : g_run
    los_persist_ctr #(
      .PERSIST (PERSIST)
    ) u_ctr (
      .clk       (clk),
      .rst_n     (rst_core_n),
      .qualify_i (run_qual[g]),
      .done_o    (run_done[g])
    );
  end

  los_alarm_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_core_n),
    .detect_off_i (detect_off),
    .raise_hit_i  (run_done[los_pkg::RUN_RAISE]),
    .clear_hit_i  (run_done[los_pkg::RUN_CLEAR]),
    .state_o      (alarm_q),
    .state_next_o (alarm_d)
  );

  // Gate on the next alarm value so data and alarm switch together.
  los_squelch u_squelch (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .squelch_i (alarm_d == los_pkg::LOS_SET),
    .data_i    (rx_data_i),
    .data_o    (rx_data_o)
  );

  assign los_o = (alarm_q == los_pkg::LOS_SET);

endmodule

// File: rtl/los_qualifier_chk.sv
module los_qualifier_chk #(
  parameter int unsigned PERSIST = 80
) (
  input logic clk,
  input logic rst_n,
  input logic below_assert_i,
  input logic above_clear_i,
  input logic monitor_en_i,
  input logic loopback_en_i,
  input logic rx_data_i,
  input logic rx_data_o,
  input logic los_o
);

  localparam int unsigned RW = $clog2(PERSIST + 2);

  logic          armed_q;
  logic [RW-1:0] run_lo_q;
  logic [RW-1:0] run_hi_q;
  logic          off_w;

  assign off_w = monitor_en_i || loopback_en_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q  <= 1'b0;
      run_lo_q <= '0;
      run_hi_q <= '0;
    end else begin
      armed_q <= 1'b1;
      if (!los_o && below_assert_i && !off_w) begin
        if (run_lo_q <= RW'(PERSIST)) run_lo_q <= run_lo_q + RW'(1);
      end else begin
        run_lo_q <= '0;
      end
      if (los_o && above_clear_i && !off_w) begin
        if (run_hi_q <= RW'(PERSIST)) run_hi_q <= run_hi_q + RW'(1);
      end else begin
        run_hi_q <= '0;
      end
    end
  end

  assert_rise_after_run_R2: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
    $rose(los_o) |-> (run_lo_q == RW'(PERSIST)));

  assert_run_completes_R3: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
    (run_lo_q == RW'(PERSIST)) |-> los_o);

  assert_fall_after_run_R4: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
    ($fell(los_o) && !$past(off_w)) |-> (run_hi_q == RW'(PERSIST)));

  assert_clear_completes_R5: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
    (run_hi_q == RW'(PERSIST)) |-> !los_o);

  assert_pass_through_R7: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
    !los_o |-> (rx_data_o == $past(rx_data_i)));

  assert_squelch_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    los_o |-> !rx_data_o);

  // R11 shares this check through off_w.
  assert_modes_hold_low_R10: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
    $past(off_w) |-> !los_o);

endmodule

bind los_qualifier los_qualifier_chk #(.PERSIST(PERSIST)) u_chk (
  .clk            (clk),
  .rst_n          (rst_core_n),
  .below_assert_i (below_assert_i),
  .above_clear_i  (above_clear_i),
  .monitor_en_i   (monitor_en_i),
  .loopback_en_i  (loopback_en_i),
  .rx_data_i      (rx_data_i),
  .rx_data_o      (rx_data_o),
  .los_o          (los_o)
);

// File: tb/los_qualifier_bench.sv
module los_qualifier_bench;

  localparam int unsigned PERSIST = 80;

  logic clk = 1'b0;
  logic rst_n;
  logic below, above, mon, lb, din;
  logic dout, los;
  int   checks = 0;
  int   errors = 0;
  bit   done   = 1'b0;

  always #10 clk = ~clk;

  los_qualifier #(.PERSIST(PERSIST)) u_los_qualifier (
    .clk            (clk),
    .rst_n          (rst_n),
    .below_assert_i (below),
    .above_clear_i  (above),
    .monitor_en_i   (mon),
    .loopback_en_i  (lb),
    .rx_data_i      (din),
    .rx_data_o      (dout),
    .los_o          (los)
  );

  task automatic chk(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  // Entered and left at a falling edge; one rising edge in between.
  task automatic cyc(input logic b, input logic a, input logic d);
    below = b; above = a; din = d;
    @(negedge clk);
  endtask

  task automatic run(input int n, input logic b, input logic a);
    for (int i = 0; i < n; i++) cyc(b, a, 1'b0);
  endtask

  task automatic go_set();
    run(PERSIST, 1'b1, 1'b0);
  endtask

  task automatic go_clear();
    run(PERSIST, 1'b0, 1'b1);
  endtask

  task automatic t_reset_R1();
    rst_n = 1'b0; below = 1'b1; above = 1'b0; mon = 1'b0; lb = 1'b0; din = 1'b1;
    repeat (PERSIST + 5) @(negedge clk);
    chk(los, 1'b0, "R1 los during reset");
    chk(dout, 1'b0, "R1 data during reset");
    below = 1'b0; din = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(los, 1'b0, "R1 los after reset");
  endtask

  task automatic t_raise_R2();
    run(PERSIST - 1, 1'b1, 1'b0);
    chk(los, 1'b0, "R2 after PERSIST-1 UI");
    cyc(1'b1, 1'b0, 1'b0);
    chk(los, 1'b1, "R2 after PERSIST UI");
    cyc(1'b1, 1'b0, 1'b0);
    chk(los, 1'b1, "R2 after PERSIST+1 UI");
    go_clear();
  endtask

  task automatic t_raise_break_R3();
    run(50, 1'b1, 1'b0);
    cyc(1'b0, 1'b0, 1'b0);
    run(PERSIST - 1, 1'b1, 1'b0);
    chk(los, 1'b0, "R3 restarted run one short");
    cyc(1'b1, 1'b0, 1'b0);
    chk(los, 1'b1, "R3 restarted run complete");
    go_clear();
  endtask

  task automatic t_clear_R4();
    go_set();
    run(PERSIST - 1, 1'b0, 1'b1);
    chk(los, 1'b1, "R4 after PERSIST-1 UI");
    cyc(1'b0, 1'b1, 1'b0);
    chk(los, 1'b0, "R4 after PERSIST UI");
  endtask

  task automatic t_clear_break_R5();
    go_set();
    run(50, 1'b0, 1'b1);
    cyc(1'b0, 1'b0, 1'b0);
    run(PERSIST - 1, 1'b0, 1'b1);
    chk(los, 1'b1, "R5 restarted clear one short");
    cyc(1'b0, 1'b1, 1'b0);
    chk(los, 1'b0, "R5 restarted clear complete");
  endtask

  task automatic t_ignore_R6();
    run(2 * PERSIST, 1'b0, 1'b1);
    chk(los, 1'b0, "R6 clear flag while low");
    go_set();
    run(2 * PERSIST, 1'b1, 1'b0);
    chk(los, 1'b1, "R6 raise flag while high");
    go_clear();
    chk(los, 1'b0, "R6 clear run unaffected");
  endtask

  task automatic t_pass_R7();
    for (int i = 0; i < 64; i++) begin
      logic d;
      d = 1'($urandom);
      cyc(1'b0, 1'b0, d);
      chk(dout, d, "R7 pass-through");
    end
  endtask

  task automatic t_squelch_R8();
    go_set();
    for (int i = 0; i < 64; i++) begin
      cyc(1'b1, 1'b0, 1'($urandom));
      chk(dout, 1'b0, "R8 squelched data");
    end
    go_clear();
  endtask

  task automatic t_edges_R9();
    for (int i = 0; i < int'(PERSIST) - 1; i++) cyc(1'b1, 1'b0, 1'b1);
    chk(dout, 1'b1, "R9 data before raise");
    cyc(1'b1, 1'b0, 1'b1);
    chk(los, 1'b1, "R9 alarm raised");
    chk(dout, 1'b0, "R9 squelch same edge as raise");
    for (int i = 0; i < int'(PERSIST) - 1; i++) cyc(1'b0, 1'b1, 1'b1);
    chk(dout, 1'b0, "R9 data before fall");
    cyc(1'b0, 1'b1, 1'b1);
    chk(los, 1'b0, "R9 alarm fell");
    chk(dout, 1'b1, "R9 release same edge as fall");
  endtask

  task automatic t_mode(input bit use_lb, input string req);
    run(PERSIST - 1, 1'b1, 1'b0);
    mon = !use_lb; lb = use_lb;
    cyc(1'b1, 1'b0, 1'b0);
    mon = 1'b0; lb = 1'b0;
    chk(los, 1'b0, {req, " no raise in mode"});
    run(PERSIST - 1, 1'b1, 1'b0);
    chk(los, 1'b0, {req, " partial run discarded"});
    cyc(1'b1, 1'b0, 1'b0);
    chk(los, 1'b1, {req, " fresh run completes"});
    mon = !use_lb; lb = use_lb;
    cyc(1'b1, 1'b0, 1'b1);
    chk(los, 1'b0, {req, " alarm forced low"});
    chk(dout, 1'b1, {req, " data passes in mode"});
    cyc(1'b1, 1'b0, 1'b0);
    mon = 1'b0; lb = 1'b0;
    cyc(1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset_R1();
    t_raise_R2();
    t_raise_break_R3();
    t_clear_R4();
    t_clear_break_R5();
    t_ignore_R6();
    t_pass_R7();
    t_squelch_R8();
    t_edges_R9();
    t_mode(1'b0, "R10");
    t_mode(1'b1, "R11");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule